// File: doc/BRIEF.md
# Serial NOR Flash Responder

This block is the target end of an SPI link: it stands in for a serial NOR flash so that a host controller can read identification, status and data from it over one, two or four I/O lines. Chip select, serial clock and the four host-driven data lines are brought into the block's own clock domain through a short synchronizer. Every SCK edge is then detected as a single-cycle event. The block samples on rising SCK and drives on falling SCK, which is SPI mode 0.

A command always starts with an 8-bit opcode, sent MSB first on IO0. The read commands then take a 24-bit address, MSB first, at the width of that command. Some of them wait a fixed number of dummy clocks before data flows. Read data comes from an on-chip byte array of `MEM_BYTES` entries. The address advances after every byte and wraps at the end of the array. Address bits above the array index are discarded.

The status byte carries the write-enable latch and the quad-enable flag. A write-status command changes the quad-enable flag only when it is write-enabled. The identification bytes describe a 256 Mbit part made of 512 sectors of 64 KiB, with a 4 KiB small-erase size. The array behind the bytes is the parameter-sized one.

Top module: `qnor_responder`

## Requirements
- R1: After a synchronous reset, the write-enable latch and quad enable are 0 and every `spi_io_oe` bit is 0.
- R2: Opcode 0x9F returns 0x9D, 0x70, 0x19 on IO1, MSB first, repeating in that order for as long as clocks continue; `spi_io_oe` is 0010.
- R3: Opcode 0x05 returns the status byte on IO1, repeated. Bit 1 is the write-enable latch, bit 6 is quad enable, and all other bits are 0.
- R4: Opcode 0x06 sets the write-enable latch.
- R5: Opcode 0x01 followed by one data byte copies data bit 6 into quad enable and clears the write-enable latch. This happens only if the latch was set; otherwise the command changes nothing.
- R6: Opcode 0x03 takes 24 address bits on IO0. The first data bit appears on IO1 at the falling edge after the last address bit, with no dummy clocks.
- R7: Opcode 0x0B takes 24 address bits on IO0, then 8 dummy clocks, then returns data on IO1.
- R8: Opcode 0xBB takes the address 2 bits per clock, with IO1 carrying the higher bit. It waits 4 dummy clocks, then returns data 2 bits per clock on IO1:IO0 with `spi_io_oe` = 0011.
- R9: Opcode 0xEB, when quad enable is 1, takes the address 4 bits per clock with IO3 as the highest bit. It waits 6 dummy clocks, then returns data 4 bits per clock on IO3..IO0 with `spi_io_oe` = 1111. When quad enable is 0, the command is ignored and no output is enabled.
- R10: The array byte at index a is (a*5 + (a>>8)*17 + 60) mod 256. The index is the address modulo `MEM_BYTES`. It increments after each byte and wraps from `MEM_BYTES`-1 to 0.
- R11: Raising chip select aborts any command. All `spi_io_oe` bits drop within three clocks, and the next selection starts a fresh opcode.
- R12: An SCK rising edge that reaches the decoder in the same cycle as the chip-select release is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples SCK |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_io_i | input | 4 | Host-driven levels of IO3..IO0 |
| spi_io_o | output | 4 | Levels the responder drives on IO3..IO0 |
| spi_io_oe | output | 4 | Per-line output enable for IO3..IO0 |

## Verification
The decoder can see a chip-select release and an SCK rising edge in the same cycle. Both travel through the same synchronizer depth, so the bench provokes this by raising SCK and chip select on the same clock while the eighth bit of a write-enable opcode is on IO0. A following status read must show the latch still clear, which is how the edge is judged to have been dropped. The second overlap is a falling edge and an abort: the bench releases chip select halfway through a data byte. It then checks, on every clock, that the enables have fallen and stay low while the device is deselected.

// File: rtl/qnr_pkg.sv
package qnr_pkg;
  localparam logic [7:0] OP_ID   = 8'h9F;
  localparam logic [7:0] OP_RDST = 8'h05;
  localparam logic [7:0] OP_WRST = 8'h01;
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_RD   = 8'h03;
  localparam logic [7:0] OP_FRD  = 8'h0B;
  localparam logic [7:0] OP_DRD  = 8'hBB;
  localparam logic [7:0] OP_QRD  = 8'hEB;

  localparam logic [7:0] ID_MFR  = 8'h9D;
  localparam logic [7:0] ID_TYPE = 8'h70;
  localparam logic [7:0] ID_CAP  = 8'h19;

  localparam logic [3:0] DUM_FRD = 4'd8;
  localparam logic [3:0] DUM_DRD = 4'd4;
  localparam logic [3:0] DUM_QRD = 4'd6;

  typedef enum logic [2:0] {ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA, ST_WRST, ST_IGN} phase_t;
  typedef enum logic [1:0] {LN_X1, LN_X2, LN_X4} lane_t;
  typedef enum logic [1:0] {SRC_ID, SRC_STAT, SRC_MEM} src_t;

  // Fill pattern of the array: index a holds a*5 + (a>>8)*17 + 60, low byte.
  function automatic logic [7:0] fill_byte(input int unsigned a);
    int unsigned v;
    v = a * 5 + (a >> 8) * 17 + 60;
    return v[7:0];
  endfunction
endpackage

// File: rtl/qnr_sync.sv
module qnr_sync #(
  parameter int W = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st <= {STAGES{RST_VAL}};
    else     st <= {st[STAGES-2:0], din};
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/qnr_array.sv
module qnr_array import qnr_pkg::*; #(
  parameter int DEPTH = 512,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = fill_byte(i);
  end

  always_ff @(posedge clk) q <= mem[addr];
endmodule

// File: rtl/qnr_engine.sv
module qnr_engine import qnr_pkg::*; #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csn_s,
  input  logic          sck_s,
  input  logic [3:0]    io_s,
  input  logic [7:0]    mem_q,
  output logic [AW-1:0] rd_addr,
  output logic [3:0]    io_o,
  output logic [3:0]    io_oe
);
  logic          sck_d;
  logic          rise, fall;
  phase_t        phase;
  lane_t         lane;
  src_t          src;
  logic [4:0]    cnt;
  logic [3:0]    ndum;
  logic [6:0]    sh;
  logic [AW-1:0] addr;
  logic [1:0]    id_idx;
  logic [7:0]    obuf;
  logic [2:0]    pos;
  logic          wel, qe;
  logic [7:0]    in_byte;
  logic [AW-1:0] addr_nx;
  logic [4:0]    addr_last;
  logic [2:0]    pos_last;
  logic [7:0]    src_byte, cur;

  assign rise    = sck_s & ~sck_d;
  assign fall    = ~sck_s & sck_d;
  assign in_byte = {sh, io_s[0]};
  assign rd_addr = addr;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  // Lane width picks the address shift, its length and the steps per byte.
  always_comb begin
    case (lane)
      LN_X2: begin
        addr_nx = {addr[AW-3:0], io_s[1:0]};
        addr_last = 5'd11;
        pos_last = 3'd3;
      end
      LN_X4: begin
        addr_nx = {addr[AW-5:0], io_s};
        addr_last = 5'd5;
        pos_last = 3'd1;
      end
      default: begin
        addr_nx = {addr[AW-2:0], io_s[0]};
        addr_last = 5'd23;
        pos_last = 3'd7;
      end
    endcase
  end

  always_comb begin
    case (src)
      SRC_ID:   src_byte = (id_idx == 2'd0) ? ID_MFR : (id_idx == 2'd1) ? ID_TYPE : ID_CAP;
      SRC_STAT: src_byte = {1'b0, qe, 4'b0000, wel, 1'b0};
      default:  src_byte = mem_q;
    endcase
    cur = (pos == 3'd0) ? src_byte : obuf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= ST_OPC;
      lane <= LN_X1;
      src <= SRC_MEM;
      cnt <= '0;
      ndum <= '0;
      sh <= '0;
      addr <= '0;
      id_idx <= '0;
      obuf <= '0;
      pos <= '0;
      wel <= 1'b0;
      qe <= 1'b0;
      io_o <= '0;
      io_oe <= '0;
    end else if (csn_s) begin
      // Deselect wins over any edge seen in the same cycle.
      phase <= ST_OPC;
      cnt <= '0;
      pos <= '0;
      id_idx <= '0;
      io_o <= '0;
      io_oe <= '0;
    end else if (rise) begin
      case (phase)
        ST_OPC: begin
          sh <= in_byte[6:0];
          cnt <= cnt + 5'd1;
          if (cnt == 5'd7) begin
            cnt <= '0;
            lane <= LN_X1;
            ndum <= '0;
            src <= SRC_MEM;
            case (in_byte)
              OP_ID:   begin phase <= ST_DATA; src <= SRC_ID; end
              OP_RDST: begin phase <= ST_DATA; src <= SRC_STAT; end
              OP_WEN:  begin wel <= 1'b1; phase <= ST_IGN; end
              OP_WRST: phase <= ST_WRST;
              OP_RD:   phase <= ST_ADDR;
              OP_FRD:  begin phase <= ST_ADDR; ndum <= DUM_FRD; end
              OP_DRD:  begin phase <= ST_ADDR; lane <= LN_X2; ndum <= DUM_DRD; end
              OP_QRD: begin
                if (qe) begin phase <= ST_ADDR; lane <= LN_X4; ndum <= DUM_QRD; end
                else phase <= ST_IGN;
              end
              default: phase <= ST_IGN;
            endcase
          end
        end
        ST_ADDR: begin
          addr <= addr_nx;
          cnt <= cnt + 5'd1;
          if (cnt == addr_last) begin
            cnt <= '0;
            phase <= (ndum == 4'd0) ? ST_DATA : ST_DUMMY;
          end
        end
        ST_DUMMY: begin
          cnt <= cnt + 5'd1;
          if (cnt == ({1'b0, ndum} - 5'd1)) begin
            cnt <= '0;
            phase <= ST_DATA;
          end
        end
        ST_WRST: begin
          sh <= in_byte[6:0];
          cnt <= cnt + 5'd1;
          if (cnt == 5'd7) begin
            cnt <= '0;
            phase <= ST_IGN;
            if (wel) begin
              qe <= in_byte[6];
              wel <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end else if (fall && phase == ST_DATA) begin
      case (lane)
        LN_X2: begin
          io_o <= {2'b00, cur[7:6]};
          io_oe <= 4'b0011;
          obuf <= {cur[5:0], 2'b00};
        end
        LN_X4: begin
          io_o <= cur[7:4];
          io_oe <= 4'b1111;
          obuf <= {cur[3:0], 4'b0000};
        end
        default: begin
          io_o <= {2'b00, cur[7], 1'b0};
          io_oe <= 4'b0010;
          obuf <= {cur[6:0], 1'b0};
        end
      endcase
      if (pos == pos_last) begin
        pos <= '0;
        addr <= addr + AW'(1);
        id_idx <= (id_idx == 2'd2) ? 2'd0 : id_idx + 2'd1;
      end else begin
        pos <= pos + 3'd1;
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!wel && !qe && io_oe == 4'b0000));

  // R11
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> (io_oe == 4'b0000));

  // R5
  qe_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (qe != $past(qe)) |-> $past(wel));

  // R9
  quad_needs_qe_chk: assert property (@(posedge clk) disable iff (rst)
    io_oe[3] |-> qe);

  // R8
  oe_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (io_oe == 4'b0000) || (io_oe == 4'b0010) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

  // R4
  wel_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(phase == ST_OPC));
endmodule

// File: rtl/qnor_responder.sv
module qnor_responder #(
  parameter int MEM_BYTES = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_csn,
  input  logic       spi_sck,
  input  logic [3:0] spi_io_i,
  output logic [3:0] spi_io_o,
  output logic [3:0] spi_io_oe
);
  localparam int AW = $clog2(MEM_BYTES);

  logic [5:0]    sync_q;
  logic [AW-1:0] rd_addr;
  logic [7:0]    mem_q;

  qnr_sync #(.W(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b100000)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  ({spi_csn, spi_sck, spi_io_i}),
    .dout (sync_q)
  );

  qnr_array #(.DEPTH(MEM_BYTES), .AW(AW)) array_i (
    .clk  (clk),
    .addr (rd_addr),
    .q    (mem_q)
  );

  qnr_engine #(.AW(AW)) engine_i (
    .clk     (clk),
    .rst     (rst),
    .csn_s   (sync_q[5]),
    .sck_s   (sync_q[4]),
    .io_s    (sync_q[3:0]),
    .mem_q   (mem_q),
    .rd_addr (rd_addr),
    .io_o    (spi_io_o),
    .io_oe   (spi_io_oe)
  );
endmodule

// File: tb/qnor_responder_tb_top.sv
module qnor_responder_tb_top;
  localparam int HALF = 6;
  localparam int MEM = 512;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, csn, sck;
  logic [3:0] io_i, io_o, io_oe;
  int checks = 0, errors = 0, idle_cnt = 0, oe_viol = 0;
  bit wel_m = 0, qe_m = 0;
  logic [7:0] exp_q[$];

  qnor_responder #(.MEM_BYTES(MEM)) dut_i (
    .clk(clk), .rst(rst), .spi_csn(csn), .spi_sck(sck),
    .spi_io_i(io_i), .spi_io_o(io_o), .spi_io_oe(io_oe)
  );

  function automatic logic [7:0] fill_m(input int a);
    int v;
    v = a * 5 + (a / 256) * 17 + 60;
    return 8'(v % 256);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] drv, output logic [3:0] smp, output logic [3:0] smp_oe);
    io_i = drv;
    repeat (HALF) @(negedge clk);
    smp = io_o;
    smp_oe = io_oe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic begin_tx();
    csn = 1'b0;
    io_i = '0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic end_tx();
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [3:0] s, o;
    for (int i = 7; i >= 0; i--) cyc({3'b000, b[i]}, s, o);
  endtask

  task automatic send_addr(input logic [23:0] a, input int w);
    logic [3:0] s, o, chunk;
    for (int k = 0; k < 24 / w; k++) begin
      chunk = 4'((a >> (24 - w * (k + 1))) & ((1 << w) - 1));
      cyc(chunk, s, o);
    end
  endtask

  task automatic read_bytes(input int w, input logic [3:0] mask, input string req);
    logic [3:0] s, o;
    logic [7:0] b;
    bit oe_ok;
    logic [3:0] bad_oe;
    for (int j = 0; j < exp_q.size(); j++) begin
      b = '0;
      oe_ok = 1;
      bad_oe = mask;
      for (int k = 0; k < 8 / w; k++) begin
        cyc(4'b0000, s, o);
        if (w == 1) b = {b[6:0], s[1]};
        else if (w == 2) b = {b[5:0], s[1:0]};
        else b = {b[3:0], s};
        if (o !== mask) begin oe_ok = 0; bad_oe = o; end
      end
      check(b == exp_q[j], req, $sformatf("data byte %0d", j), b, exp_q[j]);
      check(oe_ok, req, $sformatf("output enable byte %0d", j), bad_oe, mask);
    end
  endtask

  task automatic rd_status(input int n, input string req);
    begin_tx();
    send_byte(8'h05);
    exp_q = {};
    repeat (n) exp_q.push_back({1'b0, qe_m, 4'b0000, wel_m, 1'b0});
    read_bytes(1, 4'b0010, req);
    end_tx();
  endtask

  task automatic simple_cmd(input logic [7:0] op);
    begin_tx();
    send_byte(op);
    end_tx();
    if (op == 8'h06) wel_m = 1;
  endtask

  task automatic wr_status(input logic [7:0] d);
    begin_tx();
    send_byte(8'h01);
    send_byte(d);
    end_tx();
    if (wel_m) begin qe_m = d[6]; wel_m = 0; end
  endtask

  task automatic mem_read(input logic [7:0] op, input logic [23:0] a, input int w,
                          input int ndum, input int n, input logic [3:0] mask, input string req);
    logic [3:0] s, o;
    begin_tx();
    send_byte(op);
    send_addr(a, w);
    repeat (ndum) cyc(4'b0000, s, o);
    exp_q = {};
    for (int j = 0; j < n; j++) exp_q.push_back(fill_m((int'(a) + j) % MEM));
    read_bytes(w, mask, req);
    end_tx();
  endtask

  // Deselected outputs must stay released on every clock (R11).
  always @(negedge clk) begin
    if (csn && !rst) begin
      if (idle_cnt >= 4 && io_oe != 4'b0000) oe_viol++;
      idle_cnt++;
    end else begin
      idle_cnt = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] s, o;
    bit quiet;
    rst = 1'b1; csn = 1'b1; sck = 1'b0; io_i = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(io_oe == 4'b0000, "R1", "enables after reset", io_oe, 0);
    rd_status(2, "R1");

    // R2 identification, wrapping over its three bytes
    begin_tx();
    send_byte(8'h9F);
    exp_q = {8'h9D, 8'h70, 8'h19, 8'h9D};
    read_bytes(1, 4'b0010, "R2");
    end_tx();

    // R5 write status without the latch has no effect
    wr_status(8'h40);
    rd_status(1, "R5");

    // R4 / R3 latch visible in bit 1
    simple_cmd(8'h06);
    rd_status(2, "R4");

    // R5 accepted write sets quad enable, clears latch
    wr_status(8'h40);
    rd_status(1, "R5");

    mem_read(8'h03, 24'h000010, 1, 0, 4, 4'b0010, "R6");
    mem_read(8'h0B, 24'h00001F, 1, 8, 3, 4'b0010, "R7");
    mem_read(8'hBB, 24'h0000A3, 2, 4, 3, 4'b0011, "R8");
    mem_read(8'hEB, 24'h000107, 4, 6, 4, 4'b1111, "R9");
    mem_read(8'h03, 24'h7F01FE, 1, 0, 4, 4'b0010, "R10");

    // R11 abort in the middle of a data byte
    begin_tx();
    send_byte(8'h03);
    send_addr(24'h000040, 1);
    repeat (4) cyc(4'b0000, s, o);
    csn = 1'b1;
    repeat (4) @(negedge clk);
    check(io_oe == 4'b0000, "R11", "enables after abort", io_oe, 0);
    repeat (4 * HALF) @(negedge clk);
    rd_status(1, "R11");

    // R12 chip-select release lands with the eighth opcode edge
    begin_tx();
    for (int i = 7; i >= 1; i--) cyc({3'b000, 8'h06 >> i & 8'h01 ? 1'b1 : 1'b0}, s, o);
    io_i = 4'b0000;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    csn = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
    repeat (4 * HALF) @(negedge clk);
    rd_status(1, "R12");

    // R9 quad read refused once quad enable is cleared
    simple_cmd(8'h06);
    wr_status(8'h00);
    rd_status(1, "R3");
    begin_tx();
    send_byte(8'hEB);
    send_addr(24'h000107, 4);
    quiet = 1;
    for (int k = 0; k < 6 + 16; k++) begin
      cyc(4'b0000, s, o);
      if (o != 4'b0000) quiet = 0;
    end
    check(quiet, "R9", "enables with quad off", quiet ? 0 : 1, 0);
    end_tx();

    check(oe_viol == 0, "R11", "enable cycles while deselected", oe_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule